// File: doc/BRIEF.md
# Sequential Matrix Multiply Engine

This block multiplies two square matrices of signed 16-bit integers and leaves the signed 32-bit product matrix in an internal result memory. It has one multiply-accumulate datapath and steps through the output one product per clock. Three index counters drive it: row, column, and an inner sum index that moves fastest. A host-side loader first fills the two operand memories through a write port that takes an address, a data word and a flag selecting the left or right matrix. The loader then pulses `go`.

While the engine runs, `busy` is high. Each output element takes one clock per product and then one extra idle clock for its write-back. When the last element is stored, `done` pulses for one cycle. The `cycles` output then holds the number of clocks the run took. The host reads the products back through a registered read port. The matrix size `DIM` is fixed at elaboration and must be 4, 8 or 16.

Top module: `mm_seq_engine`

## Requirements
- R1: After reset, `busy`, `done` and `cycles` are all 0.
- R2: Result element (r, c) equals the sum over s of L[r][s]·R[s][c]. The operands are treated as signed two's-complement 16-bit values, and the sum is kept modulo 2^32 as a signed 32-bit value.
- R3: Each output element starts its sum from zero. Nothing from the previous element, or from an earlier run, leaks into it.
- R4: Operand and result memories are addressed row-major as row·DIM + column. `ld_sel` = 0 writes the left matrix and `ld_sel` = 1 writes the right matrix. `rd_data` shows the word at `rd_addr` one clock after the address is applied.
- R5: A `go` pulse seen while idle starts a run. `done` rises exactly DIM³ + DIM² + 1 clock edges after the edge that accepted `go`, and `busy` stays high throughout.
- R6: `done` is high for exactly one cycle, and `busy` is low from that same cycle on.
- R7: `cycles` is cleared when a run starts and counts every clock of the run. At `done` it reads DIM³ + DIM² + 1, and it holds that value until the next start.
- R8: `go` has no effect while `busy` is high. Both the run timing and the results are unchanged.
- R9: Loader writes are ignored while `busy` is high. Neither the current results nor the operand memory contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write strobe |
| ld_sel | input | 1 | Operand select: 0 left, 1 right |
| ld_addr | input | 2·log2(DIM) | Row-major operand address |
| ld_data | input | 16 | Signed operand value |
| go | input | 1 | Start pulse |
| rd_addr | input | 2·log2(DIM) | Row-major result address |
| rd_data | output | 32 | Result word, one-cycle read latency |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | 32 | Clocks taken by the last or current run |

## Verification
The hardest situations to reach are stimulus that arrives in the middle of a run: a second `go` pulse, or a loader write aimed at an operand word that has already been read. From the ports, the only way to see that either was ignored is through the timing of `done` and the final products. The bench counts clock edges after `go` and injects the stray pulse or write at a chosen count inside the run. It then compares every result with a model built from the original operands. It also reruns the multiply to show that the operand memory was not changed. Sign and wrap handling is driven with all-minimum operands, whose sum is exactly 2^32 and so wraps to zero.

// File: rtl/mm_pkg.sv
package mm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_WB    = 2'd2,
    ST_DRAIN = 2'd3
  } mm_state_t;
endpackage

// File: rtl/mm_sdp_ram.sv
module mm_sdp_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mm_seq.sv
module mm_seq
  import mm_pkg::*;
#(
  parameter int DIM  = 4,
  localparam int IDXW = $clog2(DIM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            fin,
  output logic            busy,
  output logic            iss_valid,
  output logic            iss_first,
  output logic            iss_last,
  output logic            iss_final,
  output logic [IDXW-1:0] row,
  output logic [IDXW-1:0] col,
  output logic [IDXW-1:0] kk
);
  localparam logic [IDXW-1:0] LASTI = IDXW'(DIM - 1);

  mm_state_t state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      kk    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          state <= ST_RUN;
          row   <= '0;
          col   <= '0;
          kk    <= '0;
        end
        ST_RUN: begin
          if (kk == LASTI) begin
            kk    <= '0;
            state <= ST_WB;
          end else begin
            kk <= kk + 1'b1;
          end
        end
        ST_WB: begin
          if (col == LASTI) begin
            col <= '0;
            if (row == LASTI) state <= ST_DRAIN;
            else begin
              row   <= row + 1'b1;
              state <= ST_RUN;
            end
          end else begin
            col   <= col + 1'b1;
            state <= ST_RUN;
          end
        end
        ST_DRAIN: if (fin) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (state != ST_IDLE);
    iss_valid = (state == ST_RUN);
    iss_first = iss_valid && (kk == '0);
    iss_last  = iss_valid && (kk == LASTI);
    iss_final = iss_last && (row == LASTI) && (col == LASTI);
  end

  // R3: the write-back bubble only ever follows a wrap of the inner index
  assert_wb_follows_k_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> ($past(kk) == LASTI));
endmodule

// File: rtl/mm_mac.sv
module mm_mac #(
  parameter int OPW  = 16,
  parameter int ACCW = 32,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            iss_valid,
  input  logic            iss_first,
  input  logic            iss_last,
  input  logic            iss_final,
  input  logic [IW-1:0]   iss_idx,
  input  logic [OPW-1:0]  a_q,
  input  logic [OPW-1:0]  b_q,
  output logic            wr_en,
  output logic [IW-1:0]   wr_idx,
  output logic [ACCW-1:0] wr_data,
  output logic            fin
);
  logic            s1_valid, s1_first, s1_last, s1_final;
  logic [IW-1:0]   s1_idx;
  logic            s2_final;
  logic [ACCW-1:0] acc;
  logic signed [2*OPW-1:0] prod_n;
  logic signed [ACCW-1:0]  prod_x;

  always_comb begin
    prod_n = $signed(a_q) * $signed(b_q);
    prod_x = ACCW'(prod_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
      s1_final <= 1'b0;
      s1_idx   <= '0;
      wr_en    <= 1'b0;
      s2_final <= 1'b0;
      wr_idx   <= '0;
      acc      <= '0;
    end else begin
      s1_valid <= iss_valid;
      s1_first <= iss_first;
      s1_last  <= iss_last;
      s1_final <= iss_final;
      s1_idx   <= iss_idx;
      wr_en    <= s1_valid && s1_last;
      s2_final <= s1_valid && s1_final;
      if (s1_valid) begin
        acc    <= s1_first ? prod_x : acc + prod_x;
        wr_idx <= s1_idx;
      end
    end
  end

  always_comb begin
    wr_data = acc;
    fin     = wr_en && s2_final;
  end

  // R3: one bubble separates consecutive element write-backs
  assert_wr_spaced_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);
endmodule

// File: rtl/mm_seq_engine.sv
module mm_seq_engine #(
  parameter int DIM  = 4,
  parameter int OPW  = 16,
  parameter int ACCW = 32,
  parameter int CNTW = 32,
  localparam int IDXW = $clog2(DIM),
  localparam int ADRW = 2 * IDXW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [ADRW-1:0] ld_addr,
  input  logic [OPW-1:0]  ld_data,
  input  logic            go,
  input  logic [ADRW-1:0] rd_addr,
  output logic [ACCW-1:0] rd_data,
  output logic            busy,
  output logic            done,
  output logic [CNTW-1:0] cycles
);
  localparam int ELEMS = DIM * DIM;
  localparam int LAT   = DIM * DIM * DIM + DIM * DIM + 1;

  generate
    if (DIM != 4 && DIM != 8 && DIM != 16) begin : g_bad_dim
      $error("DIM must be 4, 8 or 16");
    end
  endgenerate

  logic            iss_valid, iss_first, iss_last, iss_final, fin;
  logic [IDXW-1:0] row, col, kk;
  logic [OPW-1:0]  a_q, b_q;
  logic            wr_en;
  logic [ADRW-1:0] wr_idx;
  logic [ACCW-1:0] wr_data;
  logic            we_a, we_b;

  always_comb begin
    we_a = ld_we && !ld_sel && !busy;
    we_b = ld_we &&  ld_sel && !busy;
  end

  mm_seq #(.DIM(DIM)) u_seq (
    .clk(clk), .rst(rst), .go(go), .fin(fin), .busy(busy),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last),
    .iss_final(iss_final), .row(row), .col(col), .kk(kk)
  );

  mm_sdp_ram #(.W(OPW), .DEPTH(ELEMS)) u_ram_a (
    .clk(clk), .we(we_a), .waddr(ld_addr), .wdata(ld_data),
    .raddr({row, kk}), .rdata(a_q)
  );

  mm_sdp_ram #(.W(OPW), .DEPTH(ELEMS)) u_ram_b (
    .clk(clk), .we(we_b), .waddr(ld_addr), .wdata(ld_data),
    .raddr({kk, col}), .rdata(b_q)
  );

  mm_mac #(.OPW(OPW), .ACCW(ACCW), .IW(ADRW)) u_mac (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_first(iss_first), .iss_last(iss_last),
    .iss_final(iss_final), .iss_idx({row, col}),
    .a_q(a_q), .b_q(b_q),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .fin(fin)
  );

  mm_sdp_ram #(.W(ACCW), .DEPTH(ELEMS)) u_ram_c (
    .clk(clk), .we(wr_en), .waddr(wr_idx), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      cycles <= '0;
    end else begin
      done <= fin;
      if (go && !busy) cycles <= '0;
      else if (busy)   cycles <= cycles + 1'b1;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (cycles == CNTW'(LAT)));
  assert_go_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && go) |=> (cycles != '0));
endmodule

// File: tb/tb_mm_seq_engine.sv
module tb_mm_seq_engine;
  localparam int N      = 4;
  localparam int ADRW   = 2 * $clog2(N);
  localparam int NN     = N * N;
  localparam int LAT    = N * N * N + N * N + 1;
  localparam int CLK_PS = 10;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            ld_we = 1'b0, ld_sel = 1'b0, go = 1'b0;
  logic [ADRW-1:0] ld_addr = '0, rd_addr = '0;
  logic [15:0]     ld_data = '0;
  logic [31:0]     rd_data, cycles;
  logic            busy, done;

  int tests = 0, fails = 0;
  logic signed [15:0] ma [NN];
  logic signed [15:0] mb [NN];

  always #(CLK_PS / 2) clk = ~clk;

  mm_seq_engine #(.DIM(N)) dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .go(go), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .cycles(cycles)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [31:0] expc(input int r, input int c);
    logic signed [31:0] s = 0;
    for (int q = 0; q < N; q++) begin
      int p;
      p = ma[r * N + q] * mb[q * N + c];
      s = s + p;
    end
    return s;
  endfunction

  task automatic put(input logic sel, input int idx, input logic [15:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_sel = sel; ld_addr = ADRW'(idx); ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic load_all();
    for (int x = 0; x < NN; x++) begin
      put(1'b0, x, ma[x]);
      put(1'b1, x, mb[x]);
    end
  endtask

  // Starts a run; returns edges from accept to done. Optional mid-run pokes.
  task automatic run(input int poke_go, input int poke_ld, output int n);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk); n++;
      @(negedge clk);
      go = (n == poke_go);
      ld_we = (n == poke_ld); ld_sel = 1'b0; ld_addr = '0; ld_data = 16'h1234;
    end
    go = 1'b0; ld_we = 1'b0;
  endtask

  task automatic verify_c(input string req);
    for (int x = 0; x < NN; x++) begin
      logic signed [31:0] e;
      e = expc(x / N, x % N);
      @(negedge clk); rd_addr = ADRW'(x);
      @(negedge clk);
      chk(rd_data == e, req, $signed(rd_data), e);
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(cycles == 0, "R1 cycles", cycles, 0);
  endtask

  task automatic t_identity();
    int n;
    for (int x = 0; x < NN; x++) begin
      ma[x] = (x / N == x % N) ? 16'sd1 : 16'sd0;
      mb[x] = 16'(x * 37 - 200);
    end
    load_all();
    run(-1, -1, n);
    chk(n == LAT, "R5 latency", n, LAT);
    chk(cycles == LAT, "R7 cycles at done", cycles, LAT);
    chk(busy == 1'b0, "R6 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", done, 0);
    repeat (3) @(negedge clk);
    chk(cycles == LAT, "R7 cycles hold", cycles, LAT);
    verify_c("R4 identity row-major");
  endtask

  task automatic t_ones();
    int n;
    for (int x = 0; x < NN; x++) begin ma[x] = 16'sd1; mb[x] = 16'sd1; end
    load_all();
    run(-1, -1, n);
    verify_c("R2 ones");
  endtask

  task automatic t_signed();
    int n;
    for (int x = 0; x < NN; x++) begin ma[x] = -16'sd32768; mb[x] = -16'sd32768; end
    load_all();
    run(-1, -1, n);
    verify_c("R2 wrap to zero");
    for (int x = 0; x < NN; x++) begin
      ma[x] = (x % 2 == 1) ? -16'sd32768 : 16'sd32767;
      mb[x] = 16'(x * -1111 + 77);
    end
    load_all();
    run(-1, -1, n);
    verify_c("R2 mixed sign");
  endtask

  task automatic t_back2back();
    int n;
    for (int x = 0; x < NN; x++) begin ma[x] = 16'(3 - x); mb[x] = 16'(x * x - 9); end
    load_all();
    run(-1, -1, n);
    verify_c("R3 fresh sum after large run");
    run(-1, -1, n);
    chk(n == LAT, "R3 rerun latency", n, LAT);
    verify_c("R3 rerun same result");
  endtask

  task automatic t_go_busy();
    int n;
    for (int x = 0; x < NN; x++) begin ma[x] = 16'(x + 5); mb[x] = 16'(-x); end
    load_all();
    run(30, -1, n);
    chk(n == LAT, "R8 go while busy latency", n, LAT);
    chk(cycles == LAT, "R8 go while busy cycles", cycles, LAT);
    verify_c("R8 go while busy result");
  endtask

  task automatic t_load_busy();
    int n;
    for (int x = 0; x < NN; x++) begin ma[x] = 16'(100 + x); mb[x] = 16'(x - 8); end
    load_all();
    run(-1, 40, n);
    verify_c("R9 load while busy current run");
    run(-1, -1, n);
    verify_c("R9 operand memory unchanged");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_ones();
    t_signed();
    t_back2back();
    t_go_busy();
    t_load_busy();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule